// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Controller

This block is the digital side of an 8-bit successive-approximation analog-to-digital converter that is reached over a three-wire serial port. Its analog parts sit outside it: the sample-and-hold, the trial DAC and the comparator. The port is framed by an active-low chip select. While the select is low, the host sends a start bit and then three address bits on the serial data input. These bits pick one of four single-ended channels, or one of two differential pairs with a chosen polarity.

After the last address bit the block opens the sampling window for one clock. It then raises the busy status and runs the binary search against the comparator, one bit per clock, using the same serial clock that shifted the address in. Each decision goes out on the serial output at the next falling edge, most significant bit first, with no buffering in between. When the select goes high, both outputs float at once and the controller returns to idle. A new frame is then needed to start another conversion.

The tri-state outputs are modelled as separate data and output-enable pins.

Top module: `sar_serial_ctrl`

## Requirements
- R1: While `cs_n` is high, `dout_oe`, `sars_oe` and `sars` are 0. After one rising edge with `cs_n` high, `dac_code` is 0 and `sample_en` is 0.
- R2: In idle with `cs_n` low, a 0 on `di` is ignored. A frame starts only when `di` is 1 at a rising edge.
- R3: The three rising edges that follow the start bit capture, in this order: the mode bit (1 = single-ended, 0 = differential), the odd/sign bit, and the select bit.
- R4: `pos_sel` = {select, odd}. `diff_mode` = NOT mode. In differential mode `neg_sel` = {select, NOT odd}; in single-ended mode `neg_sel` is 0. These values hold from the sampling window until the end of the frame.
- R5: `sample_en` goes high at the rising edge that captures the select bit and stays high for exactly one clock.
- R6: `sars` rises at the rising edge that closes the sampling window. It stays high for 8 clocks, then falls.
- R7: When `sars` rises, `dac_code` is 0x80. At each rising edge while `sars` is high, the current trial bit is kept if `cmp_ge` is 1 (input at or above the DAC) and cleared otherwise, and the next lower bit becomes the trial. After 8 steps `dac_code` holds the result until `cs_n` rises.
- R8: Each decision appears on `dout` at the falling edge after the rising edge that made it, MSB first. `dout_oe` is high from the first bit until `cs_n` rises. The LSB stays on `dout` after the conversion.
- R9: In differential mode, a negative input at or above the positive input gives the code 0x00.
- R10: Raising `cs_n` at any point floats both outputs at once and returns the controller to idle at the next rising edge. With `cs_n` low again and no new start bit, no conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock. Samples `di` and runs the conversion on rising edges; drives `dout` on falling edges |
| cs_n | input | 1 | Active-low frame select |
| di | input | 1 | Serial input for the start bit and the address bits |
| cmp_ge | input | 1 | Comparator: 1 when the selected input is at or above the DAC level |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` |
| sars | output | 1 | Conversion-in-progress status |
| sars_oe | output | 1 | Output enable for `sars` |
| sample_en | output | 1 | Sampling window is open |
| diff_mode | output | 1 | 1 = differential input pair |
| pos_sel | output | 2 | Channel routed to the positive input |
| neg_sel | output | 2 | Channel routed to the negative input (0 in single-ended mode) |
| dac_code | output | 8 | Trial code for the external DAC; holds the result after conversion |

## Verification
Counting rising edges from the one that takes the start bit as edge 0: the mux selects and `sample_en` are due after edge 3, and `sars` with `dac_code` = 0x80 after edge 4. `sars` falls with the final code after edge 12. The serial bits appear at the falling edges after edges 5 to 12. The bench checks the status and code right after each of those rising edges. A monitor samples `dout` at the rising edge after each falling edge and takes exactly eight expected bits from the scoreboard queue while `dout_oe` is high. Abort and idle checks look at the enables right after `cs_n` changes, and again a few clocks later.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
    localparam int ADDR_BITS = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SAMPLE,
        ST_CONV,
        ST_DONE
    } sar_state_e;
endpackage

// File: rtl/sar_frame_fsm.sv
module sar_frame_fsm
    import sar_ctrl_pkg::*;
#(
    parameter int RES_BITS = 8
) (
    input  logic clk,
    input  logic cs_n,
    input  logic di,
    output logic addr_we,
    output logic sample_en,
    output logic conv_on
);
    localparam int CW = ($clog2(RES_BITS) > 2) ? $clog2(RES_BITS) : 2;

    sar_state_e    st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // next-state decode
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            ST_IDLE: begin
                cnt_nx = '0;
                if (di) st_nx = ST_ADDR;
            end
            ST_ADDR: begin
                if (cnt == CW'(ADDR_BITS - 1)) begin
                    st_nx  = ST_SAMPLE;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_SAMPLE: begin
                st_nx  = ST_CONV;
                cnt_nx = CW'(RES_BITS - 1);
            end
            ST_CONV: begin
                if (cnt == '0) st_nx = ST_DONE;
                else           cnt_nx = cnt - 1'b1;
            end
            ST_DONE: st_nx = ST_DONE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register; a high select forces idle
    always_ff @(posedge clk) begin
        if (cs_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        addr_we   = 1'b0;
        sample_en = 1'b0;
        conv_on   = 1'b0;
        unique case (st)
            ST_ADDR:   addr_we   = 1'b1;
            ST_SAMPLE: sample_en = 1'b1;
            ST_CONV:   conv_on   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sar_mux_decode.sv
module sar_mux_decode
    import sar_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       cs_n,
    input  logic       shift_en,
    input  logic       di,
    output logic       diff_mode,
    output logic [1:0] pos_sel,
    output logic [1:0] neg_sel
);
    logic [ADDR_BITS-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (cs_n)          addr_q <= '0;
        else if (shift_en) addr_q <= {addr_q[ADDR_BITS-2:0], di};
    end

    // addr_q[2]=mode, addr_q[1]=odd/sign, addr_q[0]=select
    always_comb begin
        diff_mode = ~addr_q[2];
        pos_sel   = {addr_q[0], addr_q[1]};
        neg_sel   = diff_mode ? {addr_q[0], ~addr_q[1]} : 2'b00;
    end
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int RES_BITS = 8
) (
    input  logic                clk,
    input  logic                cs_n,
    input  logic                load,
    input  logic                step_en,
    input  logic                cmp_ge,
    output logic [RES_BITS-1:0] dac_code,
    output logic                bit_q,
    output logic                bit_vld
);
    logic [RES_BITS-1:0] res_q, trial_q;

    always_ff @(posedge clk) begin
        if (cs_n) begin
            res_q   <= '0;
            trial_q <= '0;
            bit_q   <= 1'b0;
            bit_vld <= 1'b0;
        end else if (load) begin
            res_q   <= '0;
            trial_q <= {1'b1, {(RES_BITS-1){1'b0}}};
        end else if (step_en) begin
            if (cmp_ge) res_q <= res_q | trial_q;
            trial_q <= trial_q >> 1;
            bit_q   <= cmp_ge;
            bit_vld <= 1'b1;
        end
    end

    assign dac_code = res_q | trial_q;
endmodule

// File: rtl/sar_dout_stage.sv
module sar_dout_stage (
    input  logic clk,
    input  logic cs_n,
    input  logic bit_q,
    input  logic bit_vld,
    output logic dout,
    output logic dout_oe
);
    logic dq, en_q;

    always_ff @(negedge clk) begin
        if (cs_n) begin
            dq   <= 1'b0;
            en_q <= 1'b0;
        end else if (bit_vld) begin
            dq   <= bit_q;
            en_q <= 1'b1;
        end
    end

    assign dout    = dq;
    assign dout_oe = en_q & ~cs_n;
endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl #(
    parameter int RES_BITS = 8
) (
    input  logic                clk,
    input  logic                cs_n,
    input  logic                di,
    input  logic                cmp_ge,
    output logic                dout,
    output logic                dout_oe,
    output logic                sars,
    output logic                sars_oe,
    output logic                sample_en,
    output logic                diff_mode,
    output logic [1:0]          pos_sel,
    output logic [1:0]          neg_sel,
    output logic [RES_BITS-1:0] dac_code
);
    logic addr_we, conv_on, bit_q, bit_vld;

    sar_frame_fsm #(.RES_BITS(RES_BITS)) u_fsm (
        .clk(clk), .cs_n(cs_n), .di(di),
        .addr_we(addr_we), .sample_en(sample_en), .conv_on(conv_on)
    );

    sar_mux_decode u_mux (
        .clk(clk), .cs_n(cs_n), .shift_en(addr_we), .di(di),
        .diff_mode(diff_mode), .pos_sel(pos_sel), .neg_sel(neg_sel)
    );

    sar_approx_reg #(.RES_BITS(RES_BITS)) u_sar (
        .clk(clk), .cs_n(cs_n), .load(sample_en), .step_en(conv_on),
        .cmp_ge(cmp_ge), .dac_code(dac_code), .bit_q(bit_q), .bit_vld(bit_vld)
    );

    sar_dout_stage u_do (
        .clk(clk), .cs_n(cs_n), .bit_q(bit_q), .bit_vld(bit_vld),
        .dout(dout), .dout_oe(dout_oe)
    );

    assign sars    = conv_on & ~cs_n;
    assign sars_oe = ~cs_n;
endmodule

// File: rtl/sar_serial_ctrl_chk.sv
module sar_serial_ctrl_chk #(
    parameter int RES_BITS = 8
) (
    input logic                clk,
    input logic                cs_n,
    input logic                dout_oe,
    input logic                sars,
    input logic                sars_oe,
    input logic                sample_en,
    input logic [RES_BITS-1:0] dac_code
);
    // R1 R10
    always_comb begin
        if (cs_n === 1'b1) begin
            float_when_deselected_chk: assert (!dout_oe && !sars_oe && !sars);
        end
    end

    // R5
    window_one_clock_chk: assert property (@(posedge clk) disable iff (cs_n)
        sample_en |=> !sample_en);

    // R6
    window_then_busy_chk: assert property (@(posedge clk) disable iff (cs_n)
        sample_en |=> sars);

    // R6 R10
    busy_only_after_window_chk: assert property (@(posedge clk) disable iff (cs_n)
        $rose(sars) |-> $past(sample_en));

    // R7
    first_trial_msb_chk: assert property (@(posedge clk) disable iff (cs_n)
        $rose(sars) |-> dac_code == {1'b1, {(RES_BITS-1){1'b0}}});

    // R7
    result_held_chk: assert property (@(posedge clk) disable iff (cs_n)
        (!sars && $past(!sars) && !sample_en) |-> $stable(dac_code));
endmodule

bind sar_serial_ctrl sar_serial_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk(clk), .cs_n(cs_n), .dout_oe(dout_oe), .sars(sars),
    .sars_oe(sars_oe), .sample_en(sample_en), .dac_code(dac_code)
);

// File: tb/sim_sar_serial_ctrl.sv
`timescale 1ns/1ps
module sim_sar_serial_ctrl;
    logic clk = 1'b0;
    logic cs_n = 1'b1;
    logic di = 1'b0;
    logic cmp_ge;
    logic dout, dout_oe, sars, sars_oe, sample_en, diff_mode;
    logic [1:0] pos_sel, neg_sel;
    logic [7:0] dac_code;

    int checks = 0;
    int errors = 0;
    int ch [4];
    bit exp_q [$];
    int mon_n = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sar_serial_ctrl u0 (
        .clk(clk), .cs_n(cs_n), .di(di), .cmp_ge(cmp_ge),
        .dout(dout), .dout_oe(dout_oe), .sars(sars), .sars_oe(sars_oe),
        .sample_en(sample_en), .diff_mode(diff_mode),
        .pos_sel(pos_sel), .neg_sel(neg_sel), .dac_code(dac_code)
    );

    // analog model: comparator against the trial DAC
    always_comb begin
        int v;
        v = ch[pos_sel] - (diff_mode ? ch[neg_sel] : 0);
        cmp_ge = (v >= int'(dac_code));
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: eight serial bits per frame, popped from the scoreboard
    always @(posedge clk) begin
        #1;
        if (!dout_oe) mon_n = 0;
        else if (mon_n < 8) begin
            if (exp_q.size() == 0) chk(0, "R8 unexpected bit", dout, -1);
            else begin
                bit e;
                e = exp_q.pop_front();
                chk(dout === e, "R8 R7 serial bit", dout, e);
            end
            mon_n++;
        end
    end

    task automatic run_frame(input bit sgl, input bit odd, input bit sel, input bit abort_in_window);
        int p, n, v, code;
        p = {sel, odd};
        n = sgl ? 0 : {sel, ~odd};
        v = ch[p] - (sgl ? 0 : ch[n]);
        code = (v < 0) ? 0 : ((v > 255) ? 255 : v);   // R9 clamps to zero
        @(negedge clk); cs_n = 1'b0; di = 1'b1;
        @(negedge clk); di = sgl;
        @(negedge clk); di = odd;
        @(negedge clk); di = sel;
        @(posedge clk); #1;
        chk(sample_en === 1'b1, "R5 window open", sample_en, 1);
        chk(sars === 1'b0, "R6 idle in window", sars, 0);
        chk(diff_mode === !sgl, "R3 R4 mode", diff_mode, !sgl);
        chk(pos_sel === 2'(p), "R4 pos", pos_sel, p);
        chk(neg_sel === 2'(n), "R4 neg", neg_sel, n);
        if (abort_in_window) begin
            @(negedge clk); cs_n = 1'b1; di = 1'b0; #1;
            chk(!dout_oe && !sars_oe, "R10 float on abort", {dout_oe, sars_oe}, 0);
            @(negedge clk); cs_n = 1'b0;
            repeat (4) begin
                @(posedge clk); #1;
                chk(sars === 1'b0 && sample_en === 1'b0, "R10 no conversion", sars, 0);
            end
            chk(dac_code === 8'd0, "R10 code cleared", dac_code, 0);
            @(negedge clk); cs_n = 1'b1;
            return;
        end
        for (int b = 7; b >= 0; b--) exp_q.push_back(code[b]);
        @(posedge clk); #1;
        chk(sample_en === 1'b0, "R5 window closed", sample_en, 0);
        chk(sars === 1'b1 && sars_oe === 1'b1, "R6 busy", sars, 1);
        chk(dac_code === 8'h80, "R7 first trial", dac_code, 'h80);
        repeat (7) begin
            @(posedge clk); #1;
            chk(sars === 1'b1, "R6 busy held", sars, 1);
        end
        @(posedge clk); #1;
        chk(sars === 1'b0, "R6 busy ends", sars, 0);
        chk(dac_code === 8'(code), "R7 R9 result", dac_code, code);
        @(posedge clk); #1;
        chk(dout_oe === 1'b1 && dout === code[0], "R8 lsb held", dout, code[0]);
        chk(dac_code === 8'(code), "R7 result held", dac_code, code);
        @(negedge clk); cs_n = 1'b1; di = 1'b0; #1;
        chk(!dout_oe && !sars_oe && !sars, "R1 R10 float", {dout_oe, sars_oe, sars}, 0);
        chk(exp_q.size() == 0, "R8 all bits seen", exp_q.size(), 0);
        @(negedge clk);
    endtask

    initial begin
        ch = '{8'd0, 8'd0, 8'd0, 8'd0};
        repeat (3) @(negedge clk);
        #1;
        chk(!dout_oe && !sars_oe && !sars && dac_code === 8'd0 && sample_en === 1'b0,
            "R1 deselected", {dout_oe, sars_oe, sars}, 0);
        // R2: select low, no start bit
        @(negedge clk); cs_n = 1'b0; di = 1'b0;
        repeat (5) begin
            @(posedge clk); #1;
            chk(sars === 1'b0 && sample_en === 1'b0, "R2 no start", sars, 0);
        end
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);

        ch = '{8'd173, 8'd42, 8'd255, 8'd1};
        run_frame(1, 0, 0, 0);   // ch0 single
        run_frame(1, 1, 0, 0);   // ch1 single
        run_frame(1, 0, 1, 0);   // ch2 single, all ones
        run_frame(1, 1, 1, 0);   // ch3 single
        run_frame(0, 0, 0, 0);   // ch0-ch1 = 131
        run_frame(0, 1, 0, 0);   // ch1-ch0 negative -> R9
        ch = '{8'd90, 8'd0, 8'd77, 8'd77};
        run_frame(0, 0, 1, 0);   // equal -> R9 zero
        run_frame(1, 0, 0, 0);   // ch0 = 90
        run_frame(1, 0, 1, 1);   // R10 abort in window
        ch = '{8'd0, 8'd200, 8'd0, 8'd0};
        run_frame(0, 1, 0, 0);   // ch1-ch0 = 200
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                chk(0, "watchdog", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule